// File: doc/BRIEF.md
# ATA Strobe Timing Generator

This block produces the active-low read and write strobes of a parallel ATA channel for PIO and multiword DMA cycles. Each access is described by a 32-bit timing word. The word holds two separate sets of counts. One set covers task-file (command register) accesses and the other covers data transfers. Every count is in controller clock cycles.

A one-cycle start pulse begins an access. With the pulse come a direction bit and a flag that chooses the command timing set or the data timing set. The block latches the timing word and then runs three phases in order: an optional first-cycle setup, the strobe-active phase and the strobe-inactive recovery phase. A done pulse marks the last recovery cycle. If the next access of the same kind is started in that cycle, it begins at once and has no setup phase. The block also reports whether the captured word asks for the FIFO. The FIFO request is forced off whenever the word selects PIO operation.

Top module: `ata_strobe_gen`

## Requirements
- R1: During reset and whenever busy_o is low, rd_n_o and wr_n_o are both high, done_o is low and fifo_on_o is low after reset.
- R2: A data access (cmd_i=0) holds its strobe low for timing[8:4]+1 cycles. It then holds the strobe high for timing[3:0]+1 cycles, and done_o is high in the last of those high cycles.
- R3: A task-file access (cmd_i=1) uses timing[17:13]+1 active cycles and timing[12:9]+1 inactive cycles, so a field of zero still gives a one-cycle phase.
- R4: An access accepted while idle starts a setup phase in the cycle after the start pulse is sampled. The setup phase lasts timing[24:22] cycles for data accesses and timing[27:25] cycles for task-file accesses, with busy_o high and both strobes high. A value of zero means no setup phase.
- R5: With wr_i=1 only wr_n_o is driven low, and with wr_i=0 only rd_n_o is driven low. The two strobes are never low together.
- R6: done_o is a single-cycle pulse. busy_o falls in the cycle after done_o unless a new access is accepted in the done cycle.
- R7: The timing word, direction and access kind are captured when the start pulse is accepted. Changes to timing_i, wr_i or cmd_i after that have no effect on the running access.
- R8: A start pulse that arrives while busy_o is high, outside the done cycle, is ignored. It causes no extra access and changes neither the strobe lengths nor fifo_on_o.
- R9: A start pulse in the done cycle is accepted. If its cmd_i equals that of the finishing access, the strobe goes low in the very next cycle with no setup phase. Otherwise the setup phase is applied.
- R10: fifo_on_o equals timing[31] AND timing[29] of the captured word. When bit 29 is clear (PIO operation), fifo_on_o is 0 whatever bit 31 holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse for one access |
| wr_i | input | 1 | Direction: 1 write, 0 read |
| cmd_i | input | 1 | 1 task-file access, 0 data access |
| timing_i | input | 32 | Per-device timing word |
| rd_n_o | output | 1 | Active-low read strobe |
| wr_n_o | output | 1 | Active-low write strobe |
| busy_o | output | 1 | An access is in progress |
| done_o | output | 1 | Last recovery cycle of an access |
| fifo_on_o | output | 1 | FIFO requested by the captured word |

## Verification
The assertions assume that start_i, wr_i, cmd_i and timing_i change only away from the rising clock edge. They also assume that an ignored start pulse has no other effect on the captured state, so the word latched at acceptance is the only one the checks relate to. The stimulus changes every input on the falling edge and holds start for exactly one cycle. Right after each accepted pulse it scrambles timing_i, wr_i and cmd_i, so any late sampling of those inputs shows up as wrong strobe lengths. It launches back-to-back accesses only from the cycle in which done_o is seen high.

// File: rtl/ata_strb_pkg.sv
package ata_strb_pkg;

    localparam int TW_W = 32;
    localparam int CNT_W = 5;

    // field positions inside the timing word
    localparam int DIN_LSB  = 0;
    localparam int DIN_W    = 4;
    localparam int DACT_LSB = 4;
    localparam int DACT_W   = 5;
    localparam int CIN_LSB  = 9;
    localparam int CIN_W    = 4;
    localparam int CACT_LSB = 13;
    localparam int CACT_W   = 5;
    localparam int DSU_LSB  = 22;
    localparam int DSU_W    = 3;
    localparam int CSU_LSB  = 25;
    localparam int CSU_W    = 3;
    localparam int DMA_BIT  = 29;
    localparam int FIFO_BIT = 31;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_ACT   = 2'd2,
        PH_INACT = 2'd3
    } phase_e;

    // setup: raw cycle count; act / inact: cycles minus one
    typedef struct packed {
        logic [CNT_W-1:0] setup;
        logic [CNT_W-1:0] act;
        logic [CNT_W-1:0] inact;
    } phase_len_t;

endpackage

// File: rtl/strb_field_sel.sv
module strb_field_sel
    import ata_strb_pkg::*;
#(
    parameter int TW = TW_W
) (
    input  logic [TW-1:0] timing_i,
    input  logic          cmd_i,
    output phase_len_t    len_o
);

    // bits outside the strobe timing fields are not decoded here
    logic unused_tw;
    assign unused_tw = ^{timing_i[TW-1:CSU_LSB+CSU_W], timing_i[DSU_LSB-1:CACT_LSB+CACT_W]};

    always_comb begin
        if (cmd_i) begin
            len_o.setup = CNT_W'(timing_i[CSU_LSB +: CSU_W]);
            len_o.act   = CNT_W'(timing_i[CACT_LSB +: CACT_W]);
            len_o.inact = CNT_W'(timing_i[CIN_LSB +: CIN_W]);
        end else begin
            len_o.setup = CNT_W'(timing_i[DSU_LSB +: DSU_W]);
            len_o.act   = CNT_W'(timing_i[DACT_LSB +: DACT_W]);
            len_o.inact = CNT_W'(timing_i[DIN_LSB +: DIN_W]);
        end
    end

endmodule

// File: rtl/strb_phase_ctl.sv
module strb_phase_ctl
    import ata_strb_pkg::*;
#(
    parameter int TW = TW_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          wr_i,
    input  logic          cmd_i,
    input  logic [TW-1:0] timing_i,
    input  phase_len_t    live_len_i,
    input  phase_len_t    cur_len_i,
    output logic          busy_o,
    output logic          done_o,
    output logic [TW-1:0] word_q_o,
    output logic          cmd_q_o,
    output phase_e        phase_d_o,
    output logic          wr_d_o
);

    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
        logic [TW-1:0]    word;
        logic             wr;
        logic             cmd;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic last_cyc;
    logic accept;
    logic skip_su;

    assign last_cyc = (ctl_q.ph == PH_INACT) && (ctl_q.cnt == '0);
    assign accept   = start_i && ((ctl_q.ph == PH_IDLE) || last_cyc);
    assign skip_su  = last_cyc && (cmd_i == ctl_q.cmd);

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.ph)
            PH_IDLE: ;
            PH_SETUP: begin
                if (ctl_q.cnt == '0) begin
                    ctl_d.ph  = PH_ACT;
                    ctl_d.cnt = cur_len_i.act;
                end else begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end
            end
            PH_ACT: begin
                if (ctl_q.cnt == '0) begin
                    ctl_d.ph  = PH_INACT;
                    ctl_d.cnt = cur_len_i.inact;
                end else begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end
            end
            PH_INACT: begin
                if (ctl_q.cnt == '0) begin
                    ctl_d.ph = PH_IDLE;
                end else begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end
            end
            default: ctl_d.ph = PH_IDLE;
        endcase
        if (accept) begin
            ctl_d.word = timing_i;
            ctl_d.wr   = wr_i;
            ctl_d.cmd  = cmd_i;
            if (!skip_su && (live_len_i.setup != '0)) begin
                ctl_d.ph  = PH_SETUP;
                ctl_d.cnt = live_len_i.setup - 1'b1;
            end else begin
                ctl_d.ph  = PH_ACT;
                ctl_d.cnt = live_len_i.act;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{ph: PH_IDLE, cnt: '0, word: '0, wr: 1'b0, cmd: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy_o    = (ctl_q.ph != PH_IDLE);
    assign done_o    = last_cyc;
    assign word_q_o  = ctl_q.word;
    assign cmd_q_o   = ctl_q.cmd;
    assign phase_d_o = ctl_d.ph;
    assign wr_d_o    = ctl_d.wr;

    // R6: busy only drops right after a done cycle
    a_r6_busy_drop_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(done_o));

    // R6: done never lasts two cycles
    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8: a start while busy outside the done cycle leaves the capture untouched
    a_r8_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && busy_o && !done_o) |=> ($stable(word_q_o) && $stable(cmd_q_o)));

endmodule

// File: rtl/strb_out.sv
module strb_out
    import ata_strb_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  phase_e phase_d_i,
    input  logic   wr_d_i,
    output logic   rd_n_o,
    output logic   wr_n_o
);

    typedef struct packed {
        logic rd_n;
        logic wr_n;
    } pin_t;

    pin_t pin_d, pin_q;

    always_comb begin
        pin_d.rd_n = !((phase_d_i == PH_ACT) && !wr_d_i);
        pin_d.wr_n = !((phase_d_i == PH_ACT) && wr_d_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_q <= '{rd_n: 1'b1, wr_n: 1'b1};
        end else begin
            pin_q <= pin_d;
        end
    end

    assign rd_n_o = pin_q.rd_n;
    assign wr_n_o = pin_q.wr_n;

    // R5: the two strobes are never low together
    a_r5_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_n_o || wr_n_o));

endmodule

// File: rtl/ata_strobe_gen.sv
module ata_strobe_gen
    import ata_strb_pkg::*;
#(
    parameter int TW = TW_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          wr_i,
    input  logic          cmd_i,
    input  logic [TW-1:0] timing_i,
    output logic          rd_n_o,
    output logic          wr_n_o,
    output logic          busy_o,
    output logic          done_o,
    output logic          fifo_on_o
);

    localparam int NSEL = 2;   // 0: live input word, 1: captured word

    logic [TW-1:0] word_q;
    logic          cmd_q;
    phase_e        phase_d;
    logic          wr_d;
    logic [TW-1:0] sel_word [NSEL];
    logic          sel_cmd  [NSEL];
    phase_len_t    sel_len  [NSEL];

    assign sel_word[0] = timing_i;
    assign sel_cmd[0]  = cmd_i;
    assign sel_word[1] = word_q;
    assign sel_cmd[1]  = cmd_q;

    for (genvar g = 0; g < NSEL; g++) begin : g_sel
        strb_field_sel #(.TW(TW)) u_sel (
            .timing_i (sel_word[g]),
            .cmd_i    (sel_cmd[g]),
            .len_o    (sel_len[g])
        );
    end

    strb_phase_ctl #(.TW(TW)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .wr_i       (wr_i),
        .cmd_i      (cmd_i),
        .timing_i   (timing_i),
        .live_len_i (sel_len[0]),
        .cur_len_i  (sel_len[1]),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .word_q_o   (word_q),
        .cmd_q_o    (cmd_q),
        .phase_d_o  (phase_d),
        .wr_d_o     (wr_d)
    );

    strb_out u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase_d_i (phase_d),
        .wr_d_i    (wr_d),
        .rd_n_o    (rd_n_o),
        .wr_n_o    (wr_n_o)
    );

    // PIO operation (DMA bit clear) keeps the FIFO off
    assign fifo_on_o = word_q[FIFO_BIT] && word_q[DMA_BIT];

    // R1: idle channel keeps both strobes released
    a_r1_idle_strobes_high: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (rd_n_o && wr_n_o));

    // R9: same-kind start in the done cycle drives a strobe in the next cycle
    a_r9_no_setup_chained: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && start_i && (cmd_i == cmd_q)) |=> (!rd_n_o || !wr_n_o));

endmodule

// File: tb/ata_strobe_gen_tb.sv
module ata_strobe_gen_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        wr_i = 1'b0;
    logic        cmd_i = 1'b0;
    logic [31:0] timing_i = '0;
    logic        rd_n_o, wr_n_o, busy_o, done_o, fifo_on_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    ata_strobe_gen u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .wr_i      (wr_i),
        .cmd_i     (cmd_i),
        .timing_i  (timing_i),
        .rd_n_o    (rd_n_o),
        .wr_n_o    (wr_n_o),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .fifo_on_o (fifo_on_o)
    );

    typedef struct {
        logic  wr;
        int    pre;
        int    low;
        int    post;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    logic last_cmd = 1'b0;
    logic finished = 1'b0;

    task automatic chk(input logic ok, input string tag, input string what, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    function automatic logic [31:0] mk(input int ds, input int cs, input int ca, input int ci,
                                       input int da, input int di, input logic fifo, input logic dma);
        logic [31:0] w;
        w = '0;
        w[3:0]   = di[3:0];
        w[8:4]   = da[4:0];
        w[12:9]  = ci[3:0];
        w[17:13] = ca[4:0];
        w[21:18] = 4'hA;
        w[24:22] = ds[2:0];
        w[27:25] = cs[2:0];
        w[29]    = dma;
        w[31]    = fifo;
        return w;
    endfunction

    // driver: waits until an access may be accepted, queues the expected shape
    task automatic issue(input logic wr, input logic cmd, input logic [31:0] w, input string tag);
        exp_t e;
        logic skip;
        int s, a, i;
        while (busy_o && !done_o) @(negedge clk);
        skip = busy_o && done_o && (cmd == last_cmd);
        s = cmd ? int'(w[27:25]) : int'(w[24:22]);
        a = cmd ? int'(w[17:13]) : int'(w[8:4]);
        i = cmd ? int'(w[12:9])  : int'(w[3:0]);
        e.wr = wr; e.pre = skip ? 0 : s; e.low = a + 1; e.post = i + 1; e.tag = tag;
        exp_q.push_back(e);
        last_cmd = cmd;
        start_i = 1'b1; wr_i = wr; cmd_i = cmd; timing_i = w;
        @(negedge clk);
        start_i = 1'b0; timing_i = ~w; wr_i = ~wr; cmd_i = ~cmd;  // R7: late changes must not matter
        chk(fifo_on_o == (w[31] & w[29]), "R10", "fifo_on_o", int'(fifo_on_o), int'(w[31] & w[29]));
    endtask

    task automatic settle(input int n);
        while (busy_o) @(negedge clk);
        repeat (n) @(negedge clk);
    endtask

    // monitor: measures each access at the falling edge and compares with the queue
    int   ph = 0, pre_c = 0, low_c = 0, post_c = 0;
    logic saw_rd = 1'b0, saw_wr = 1'b0, bad_shape = 1'b0;

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (busy_o) begin
                if (!rd_n_o && !wr_n_o) bad_shape = 1'b1;
                case (ph)
                    0: if (!rd_n_o || !wr_n_o) begin
                           ph = 1; low_c = 1; saw_rd = !rd_n_o; saw_wr = !wr_n_o;
                       end else pre_c++;
                    1: if (!rd_n_o || !wr_n_o) begin
                           low_c++;
                           if ((!rd_n_o) != saw_rd) bad_shape = 1'b1;
                       end else begin
                           ph = 2; post_c = 1;
                       end
                    default: begin
                        post_c++;
                        if (!rd_n_o || !wr_n_o) bad_shape = 1'b1;
                    end
                endcase
                if (done_o) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R8", "unexpected access done", 1, 0);
                    end else begin
                        exp_t e;
                        e = exp_q.pop_front();
                        chk(ph == 2 && !bad_shape, e.tag, "strobe shape (R5) phase", ph, 2);
                        chk(pre_c == e.pre, e.tag, "setup cycles (R4)", pre_c, e.pre);
                        chk(low_c == e.low, e.tag, "active cycles", low_c, e.low);
                        chk(post_c == e.post, e.tag, "inactive cycles (R6)", post_c, e.post);
                        chk(saw_wr == e.wr && saw_rd == !e.wr, e.tag, "strobe select R5 wr", int'(saw_wr), int'(e.wr));
                    end
                    ph = 0; pre_c = 0; low_c = 0; post_c = 0; bad_shape = 1'b0;
                    saw_rd = 1'b0; saw_wr = 1'b0;
                end
            end else begin
                if (ph != 0 || pre_c != 0) chk(1'b0, "R6", "busy fell without done", 0, 1);
                if (!rd_n_o || !wr_n_o || done_o) chk(1'b0, "R1", "idle outputs quiet", 0, 1);
                ph = 0; pre_c = 0; low_c = 0; post_c = 0; bad_shape = 1'b0;
            end
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(rd_n_o && wr_n_o, "R1", "strobes in reset", int'(rd_n_o & wr_n_o), 1);
        chk(!busy_o && !done_o, "R1", "busy/done in reset", int'(busy_o | done_o), 0);
        chk(!fifo_on_o, "R1", "fifo_on in reset", int'(fifo_on_o), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2: data read, setup 2, active 4, inactive 3; PIO keeps FIFO off (R10)
        issue(1'b0, 1'b0, mk(2, 5, 9, 7, 3, 2, 1'b1, 1'b0), "R2");
        settle(2);
        // R3: task-file write uses the command fields
        issue(1'b1, 1'b1, mk(6, 3, 4, 1, 0, 0, 1'b0, 1'b0), "R3");
        settle(2);
        // R3: zero command fields still give one cycle each, no setup
        issue(1'b0, 1'b1, mk(7, 0, 0, 0, 20, 15, 1'b0, 1'b0), "R3");
        settle(1);
        // R4: large data setup, minimal phases
        issue(1'b1, 1'b0, mk(7, 1, 3, 3, 0, 0, 1'b0, 1'b0), "R4");
        settle(2);
        // R7: maximum data fields, inputs scrambled after capture
        issue(1'b0, 1'b0, mk(1, 0, 0, 0, 31, 15, 1'b0, 1'b1), "R7");
        settle(2);

        // R8: start while busy is ignored
        issue(1'b1, 1'b0, mk(1, 2, 2, 2, 12, 3, 1'b0, 1'b1), "R8");
        @(negedge clk);
        start_i = 1'b1; wr_i = 1'b0; cmd_i = 1'b1; timing_i = mk(0, 0, 1, 1, 2, 2, 1'b1, 1'b1);
        @(negedge clk);
        start_i = 1'b0;
        chk(!fifo_on_o, "R8", "fifo_on after ignored start", int'(fifo_on_o), 0);
        settle(2);
        chk(exp_q.size() == 0, "R8", "pending accesses", exp_q.size(), 0);

        // R6: busy drops one cycle after done
        issue(1'b0, 1'b0, mk(0, 0, 0, 0, 1, 1, 1'b0, 1'b0), "R6");
        while (!done_o) @(negedge clk);
        @(negedge clk);
        chk(!busy_o && !done_o, "R6", "busy after done", int'(busy_o), 0);
        settle(1);

        // R9: chained accesses
        issue(1'b1, 1'b0, mk(3, 2, 1, 1, 1, 1, 1'b0, 1'b0), "R9");
        issue(1'b0, 1'b0, mk(3, 2, 1, 1, 2, 0, 1'b0, 1'b0), "R9");
        issue(1'b1, 1'b1, mk(3, 2, 1, 0, 2, 0, 1'b0, 1'b0), "R9");
        issue(1'b1, 1'b1, mk(3, 2, 0, 2, 2, 0, 1'b0, 1'b0), "R9");
        settle(2);

        // R10: FIFO follows bit 31 only in DMA operation
        issue(1'b0, 1'b0, mk(0, 0, 0, 0, 2, 1, 1'b1, 1'b1), "R10");
        settle(1);
        issue(1'b1, 1'b0, mk(1, 0, 0, 0, 2, 1, 1'b0, 1'b1), "R10");
        settle(2);

        chk(exp_q.size() == 0, "R6", "all accesses completed", exp_q.size(), 0);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule